// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns a 32-bit write into a software interrupt request. The write carries a source number and a routing code. The routing code selects the CPUs that receive the request. The set of CPUs is either a list taken from the write, every CPU except the one that wrote, only the writer, or all CPUs. The block ORs the resulting CPU mask into the pending row of that source.

The pending rows are held inside the block, one bit per CPU for each source. Other logic reads them through a combinational read port. For every accepted write, the block issues a registered one-cycle pulse that carries the source number and the final CPU mask. A write that names a source outside the implemented range is dropped and raises a one-cycle error pulse. CPU count and source count are parameters. Up to eight CPUs are supported.

Top module: `sgi_dispatch`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released, `set_pulse` and `err_pulse` are low and every pending row reads as zero. A reset applied during operation clears all pending bits.
- R2: The source number is `wr_data[9:0]`. A write with a source below NUM_SRC raises `set_pulse` in the cycle after the write, with `set_src` equal to that source.
- R3: Routing code `wr_data[25:24]` = 0 selects the list `wr_data[23:16]`, ANDed with the existing-CPU mask ((1<<NUM_CPU)-1). List bits at or above NUM_CPU are ignored.
- R4: Routing code 1 selects every existing CPU except `wr_cpu`.
- R5: Routing code 2 selects only `wr_cpu`.
- R6: Routing code 3 selects all existing CPUs, whatever the list field holds.
- R7: The mask is ORed into the pending row of the selected source. Bits that are already set stay set. Other rows do not change.
- R8: A write with a source at or above NUM_SRC raises `err_pulse` for one cycle. It produces no `set_pulse` and changes no pending bit.
- R9: A cycle without a write is followed by low `set_pulse` and low `err_pulse`. `set_src` and `set_mask` read zero whenever `set_pulse` is low.
- R10: `rd_pend` shows the pending row of `rd_src` combinationally. Bit n is CPU n, and bits at or above NUM_CPU read zero. A `rd_src` at or above NUM_SRC reads zero. The row reflects a write from the clock edge that registers `set_pulse` onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write word: source, CPU list, routing code |
| wr_cpu | input | 3 | Index of the CPU issuing the write |
| rd_src | input | 10 | Source whose pending row is read |
| set_pulse | output | 1 | One-cycle pulse for an accepted write |
| set_src | output | 10 | Source of the accepted write |
| set_mask | output | 8 | CPU mask ORed into the pending row |
| err_pulse | output | 1 | One-cycle pulse for an out-of-range source |
| rd_pend | output | 8 | Pending row of `rd_src` |

## Verification
Two functions can fall in the same cycle:
- A write updating a pending row.
- The read port observing that same row.

The bench holds `rd_src` on the source being written. It expects the old row just before the edge and the merged row just after it.

Back-to-back writes to one source also overlap, because the second merge happens while the first pulse is still visible. The bench judges this by requiring two consecutive pulses with their own masks, and a final row equal to the OR of both masks.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    localparam int MAX_CPU  = 8;
    localparam int CPU_W    = 3;
    localparam int SRC_W    = 10;
    localparam int LIST_LSB = 16;
    localparam int ROUTE_LSB = 24;

    typedef enum logic [1:0] {
        ROUTE_LIST   = 2'd0,
        ROUTE_OTHERS = 2'd1,
        ROUTE_SELF   = 2'd2,
        ROUTE_ALL    = 2'd3
    } route_e;

    typedef struct packed {
        logic               pulse;
        logic               err;
        logic [SRC_W-1:0]   src;
        logic [MAX_CPU-1:0] mask;
    } dispatch_t;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [31:0]        cmd,
    input  logic [CPU_W-1:0]   req_cpu,
    output logic [SRC_W-1:0]   src,
    output logic [MAX_CPU-1:0] mask
);
    logic [MAX_CPU-1:0] exist_m;
    logic [MAX_CPU-1:0] self_m;
    route_e             route;

    for (genvar g = 0; g < MAX_CPU; g++) begin : g_cpu
        if (g < NUM_CPU) begin : g_live
            assign exist_m[g] = 1'b1;
            assign self_m[g]  = (req_cpu == CPU_W'(g));
        end else begin : g_absent
            assign exist_m[g] = 1'b0;
            assign self_m[g]  = 1'b0;
        end
    end

    assign src   = cmd[SRC_W-1:0];
    assign route = route_e'(cmd[ROUTE_LSB +: 2]);

    always_comb begin
        unique case (route)
            ROUTE_LIST:   mask = cmd[LIST_LSB +: MAX_CPU] & exist_m;
            ROUTE_OTHERS: mask = exist_m & ~self_m;
            ROUTE_SELF:   mask = self_m;
            default:      mask = exist_m;
        endcase
    end
endmodule

// File: rtl/sgi_pend_array.sv
module sgi_pend_array
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [SRC_W-1:0]   set_idx,
    input  logic [MAX_CPU-1:0] set_mask,
    input  logic [SRC_W-1:0]   rd_idx,
    output logic [MAX_CPU-1:0] rd_bits
);
    logic [NUM_CPU-1:0] pend_d [NUM_SRC];
    logic [NUM_CPU-1:0] pend_q [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_row
        logic hit;
        assign hit = set_en && (set_idx == SRC_W'(s));

        always_comb begin
            pend_d[s] = pend_q[s];
            if (hit) begin
                pend_d[s] = pend_q[s] | set_mask[NUM_CPU-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[s] <= '0;
            end else begin
                pend_q[s] <= pend_d[s];
            end
        end
    end

    always_comb begin
        rd_bits = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (rd_idx == SRC_W'(s)) begin
                rd_bits[NUM_CPU-1:0] = pend_q[s];
            end
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    input  logic [CPU_W-1:0]   wr_cpu,
    input  logic [SRC_W-1:0]   rd_src,
    output logic               set_pulse,
    output logic [SRC_W-1:0]   set_src,
    output logic [MAX_CPU-1:0] set_mask,
    output logic               err_pulse,
    output logic [MAX_CPU-1:0] rd_pend
);
    localparam logic [SRC_W:0] SRC_LIMIT = (SRC_W+1)'(NUM_SRC);

    logic [SRC_W-1:0]   dec_src;
    logic [MAX_CPU-1:0] dec_mask;
    logic               src_ok;
    logic               accept;
    dispatch_t          out_d;
    dispatch_t          out_q;

    sgi_decode #(.NUM_CPU(NUM_CPU)) decode_i (
        .cmd     (wr_data),
        .req_cpu (wr_cpu),
        .src     (dec_src),
        .mask    (dec_mask)
    );

    assign src_ok = ({1'b0, dec_src} < SRC_LIMIT);
    assign accept = wr_en && src_ok;

    sgi_pend_array #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (accept),
        .set_idx  (dec_src),
        .set_mask (dec_mask),
        .rd_idx   (rd_src),
        .rd_bits  (rd_pend)
    );

    always_comb begin
        out_d       = '0;
        out_d.pulse = accept;
        out_d.err   = wr_en && !src_ok;
        if (accept) begin
            out_d.src  = dec_src;
            out_d.mask = dec_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign set_pulse = out_q.pulse;
    assign err_pulse = out_q.err;
    assign set_src   = out_q.src;
    assign set_mask  = out_q.mask;
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [31:0]        wr_data,
    input logic [CPU_W-1:0]   wr_cpu,
    input logic               set_pulse,
    input logic [SRC_W-1:0]   set_src,
    input logic [MAX_CPU-1:0] set_mask,
    input logic               err_pulse
);
    localparam logic [MAX_CPU-1:0] ALL_M = MAX_CPU'((1 << NUM_CPU) - 1);

    logic in_range;
    assign in_range = ({22'd0, wr_data[SRC_W-1:0]} < 32'(NUM_SRC));

    assert_pulse_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range) |=> (set_pulse && set_src == $past(wr_data[SRC_W-1:0])));

    assert_mask_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |-> ((set_mask & ~ALL_M) == '0));

    assert_not_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range && wr_data[25:24] == 2'd1) |=> !set_mask[$past(wr_cpu)]);

    assert_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_range && wr_data[25:24] == 2'd3) |=> (set_mask == ALL_M));

    assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> (err_pulse && !set_pulse));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_pulse && err_pulse));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!set_pulse && !err_pulse));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_cpu    (wr_cpu),
    .set_pulse (set_pulse),
    .set_src   (set_src),
    .set_mask  (set_mask),
    .err_pulse (err_pulse)
);

// File: tb/sgi_dispatch_tb_top.sv
`timescale 1ns/1ps
module sgi_dispatch_tb_top;
    localparam int NCPU = 4;
    localparam int NSRC = 16;
    localparam int NVEC = 10;

    // entry: {wr_data[31:0], wr_cpu[2:0], exp_err, exp_mask[7:0]}
    localparam logic [43:0] VEC [NVEC] = '{
        {32'h0005_0003, 3'd0, 1'b0, 8'h05},  // R3 list
        {32'h00F6_0003, 3'd1, 1'b0, 8'h06},  // R3 upper list bits ignored
        {32'h0100_0007, 3'd2, 1'b0, 8'h0B},  // R4
        {32'h0100_0007, 3'd0, 1'b0, 8'h0E},  // R4
        {32'h0200_0000, 3'd3, 1'b0, 8'h08},  // R5
        {32'h0200_000F, 3'd1, 1'b0, 8'h02},  // R5 top source
        {32'h0301_0009, 3'd0, 1'b0, 8'h0F},  // R6 list ignored
        {32'h0300_0010, 3'd0, 1'b1, 8'h00},  // R8 first bad source
        {32'h00FF_03FF, 3'd2, 1'b1, 8'h00},  // R8 max source
        {32'h0200_0000, 3'd0, 1'b0, 8'h01}   // R7 merge into row 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  wr_cpu = '0;
    logic [9:0]  rd_src = '0;
    logic        set_pulse;
    logic [9:0]  set_src;
    logic [7:0]  set_mask;
    logic        err_pulse;
    logic [7:0]  rd_pend;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [NSRC];

    always #2 clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NCPU), .NUM_SRC(NSRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_cpu(wr_cpu), .rd_src(rd_src), .set_pulse(set_pulse),
        .set_src(set_src), .set_mask(set_mask), .err_pulse(err_pulse),
        .rd_pend(rd_pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_row(input logic [9:0] s, output logic [7:0] v);
        rd_src = s;
        #0.5;
        v = rd_pend;
    endtask

    task automatic check_all_rows(input string req);
        logic [7:0] v;
        for (int s = 0; s < NSRC; s++) begin
            read_row(10'(s), v);
            chk(req, {24'd0, v}, {24'd0, model[s]});
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int s = 0; s < NSRC; s++) model[s] = '0;
        repeat (3) @(negedge clk);
        chk("R1 pulse in reset", {31'd0, set_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulse after reset", {30'd0, set_pulse, err_pulse}, 0);
        check_all_rows("R1 rows clear");

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [9:0] s;
            s = VEC[i][43:12] & 32'h3FF;
            wr_data = VEC[i][43:12];
            wr_cpu  = VEC[i][11:9];
            wr_en   = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            chk("R8 err pulse", {31'd0, err_pulse}, {31'd0, VEC[i][8]});
            chk("R2 set pulse", {31'd0, set_pulse}, {31'd0, !VEC[i][8]});
            chk("R2 source", {22'd0, set_src}, VEC[i][8] ? 32'd0 : {22'd0, s});
            chk("R3-6 mask", {24'd0, set_mask}, {24'd0, VEC[i][7:0]});
            if (!VEC[i][8]) begin
                model[s] = model[s] | VEC[i][7:0];
                read_row(s, v);
                chk("R7 row merge", {24'd0, v}, {24'd0, model[s]});
            end else begin
                read_row(s, v);
                chk("R10 out of range read", {24'd0, v}, 0);
            end
            @(negedge clk);
            chk("R9 pulse drops", {30'd0, set_pulse, err_pulse}, 0);
        end
        check_all_rows("R7 R8 other rows untouched");

        // R10 same-cycle read while writing the same source
        read_row(10'd5, v);
        wr_data = 32'h0002_0005; wr_cpu = 3'd0; wr_en = 1'b1;
        #0.5;
        chk("R10 old row before edge", {24'd0, rd_pend}, 0);
        @(posedge clk);
        #0.5;
        chk("R10 new row after edge", {24'd0, rd_pend}, 32'h02);
        model[5] = 8'h02;
        // back-to-back write to same source
        @(negedge clk);
        chk("R2 first pulse", {31'd0, set_pulse}, 1);
        wr_data = 32'h0200_0005; wr_cpu = 3'd3;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 second pulse mask", {23'd0, set_pulse, set_mask}, 32'h108);
        model[5] = 8'h0A;
        read_row(10'd5, v);
        chk("R7 back-to-back merge", {24'd0, v}, 32'h0A);
        @(negedge clk);
        chk("R9 idle after burst", {22'd0, set_src}, 0);

        // R4 with a requester outside the existing CPUs
        wr_data = 32'h0100_0002; wr_cpu = 3'd6; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4 absent requester", {24'd0, set_mask}, 32'h0F);

        // R1 reset mid-run clears rows
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NSRC; s++) model[s] = '0;
        chk("R1 reset pulse", {31'd0, set_pulse}, 0);
        check_all_rows("R1 mid-run reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule